// File: doc/BRIEF.md
# Watchdog Countdown Timer with Second or Minute Units

This block is a watchdog countdown timer that software reaches through a small byte-wide register file. Software writes a 16-bit count and picks whether that count is in seconds or in minutes. It must then keep rewriting the count before it runs out. When the count runs out, the block can drive a system reset, pull a power-good output low for one second and pulse an event line. Each of these actions has its own enable bit. A sticky status flag records that a timeout happened.

A one-per-second tick input sets the time base. In seconds mode every tick takes one off the count. In minutes mode a divide-by-60 prescaler sits between the tick and the counter, and each load of the count clears it. The count is written as two bytes. The high byte waits in a holding register, and the write of the low byte loads both bytes at once and arms the timer. A loaded count of zero disarms the timer and causes no timeout.

Top module: `wdt_unit_timer`

## Requirements
- R1: After reset the configuration register reads 0x80 (seconds unit, all actions off), the count reads 0 at both count addresses, the status flag reads 0, `sys_rst_o` is 0, `pwr_ok_o` is 1, and the timer is disarmed.
- R2: Register addresses: 0x71 is control (bit 0 is the status flag, other bits read 0), 0x72 is configuration (read back as written), 0x73 is the count low byte and 0x74 is the count high byte. Reads of 0x73 and 0x74 return the live remaining count.
- R3: A write to 0x74 only fills a holding register. The count at 0x73/0x74 does not change until 0x73 is written, which loads {held high byte, written low byte} in one step.
- R4: With configuration bit 7 set (seconds), an armed count drops by one on each `sec_tick` pulse, and the timeout happens on the tick that takes it from 1 to 0.
- R5: With configuration bit 7 clear (minutes), the count drops by one on every 60th `sec_tick`. Loading a count restarts the 60-tick division.
- R6: On timeout with configuration bit 6 set, `sys_rst_o` goes high after that tick's clock edge and stays high until the next `sec_tick`. With bit 6 clear it stays low.
- R7: On timeout with configuration bit 4 set, `pwr_ok_o` goes low and stays low until the next `sec_tick`. With bit 4 clear it stays high.
- R8: On timeout with configuration bit 5 set, `tmo_evt_o` is high for exactly one clock cycle.
- R9: A timeout sets control bit 0. Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R10: Loading a count of zero disarms the timer. Later ticks leave the count at 0 and cause no timeout.
- R11: Loading a nonzero count while the timer is armed restarts the countdown from the new value. This is the keepalive.
- R12: After a timeout the count reads 0, the timer is disarmed, and further ticks cause no new timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-clock pulse once per second |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| sys_rst_o | output | 1 | System reset request, held for one tick |
| pwr_ok_o | output | 1 | Power-good, driven low for one tick on timeout |
| tmo_evt_o | output | 1 | One-cycle timeout event pulse |

## Verification
The hardest case to reach from the ports is the prescaler restart in minutes mode. The division state is hidden, so the only way to see it is through when the count next drops. The stimulus lets 30 ticks pass and then reloads the count. It then shows that the timeout comes 60 ticks after the reload and not 30: after 59 ticks nothing has fired, and the next tick fires. The atomic two-byte load is checked by reading the live count after a high-byte-only write. The disarm case is checked by ticking well past where a timeout would have come.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W   = 16;
  localparam int UNIT_DIV = 60;
  localparam logic [7:0] A_CTRL = 8'h71;
  localparam logic [7:0] A_CFG  = 8'h72;
  localparam logic [7:0] A_CLO  = 8'h73;
  localparam logic [7:0] A_CHI  = 8'h74;
  localparam logic [7:0] CFG_RESET = 8'h80;
  localparam int B_SEC = 7;
  localparam int B_RST = 6;
  localparam int B_EVT = 5;
  localparam int B_PG  = 4;

  // one step down, never below zero
  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - CNT_W'(1);
  endfunction

  // modulo counter step for the unit prescaler
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       addr,
  input  logic             wr,
  input  logic [7:0]       wdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             expire,
  output logic [7:0]       rdata,
  output logic [7:0]       cfg_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             flag_o
);
  logic [7:0] cfg_q, hi_q;
  logic       flag_q;
  logic       wr_ctrl, wr_cfg, wr_lo, wr_hi;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_cfg  = wr && (addr == A_CFG);
  assign wr_lo   = wr && (addr == A_CLO);
  assign wr_hi   = wr && (addr == A_CHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      hi_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wdata;
      if (wr_hi)  hi_q  <= wdata;
      if (expire) flag_q <= 1'b1;
      else if (wr_ctrl && !wdata[0]) flag_q <= 1'b0;
    end
  end

  assign load_o     = wr_lo;
  assign load_val_o = {hi_q, wdata};
  assign cfg_o      = cfg_q;
  assign flag_o     = flag_q;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {7'b0, flag_q};
      A_CFG:   rdata = cfg_q;
      A_CLO:   rdata = cnt_val[7:0];
      A_CHI:   rdata = cnt_val[15:8];
      default: rdata = 8'h00;
    endcase
  end

  // R9: the flag drops only through a control write
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_ctrl) |=> flag_q);
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
#(
  parameter int DIV = UNIT_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic sec_mode,
  input  logic restart,
  output logic unit_tick
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (restart || sec_mode) pre_q <= '0;
    else if (sec_tick) pre_q <= PRE_W'(wrap_inc(int'(pre_q), DIV));
  end

  assign unit_tick = sec_mode ? sec_tick
                              : (sec_tick && (pre_q == PRE_W'(DIV - 1)));

  // R5: division state stays inside 0..DIV-1
  p_pre_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_q) <= DIV - 1);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             unit_tick,
  output logic [CNT_W-1:0] count,
  output logic             armed,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             arm_q;

  assign expire = arm_q && unit_tick && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      arm_q <= (load_val != '0);
    end else if (arm_q && unit_tick) begin
      cnt_q <= cnt_dec(cnt_q);
      if (expire) arm_q <= 1'b0;
    end
  end

  assign count = cnt_q;
  assign armed = arm_q;

  // R10: a zero load leaves the timer disarmed
  p_zero_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !arm_q);
  // R4: each unit tick takes exactly one off an armed count
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && unit_tick && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R12: a timeout leaves the counter disarmed at zero
  p_disarm_after_r12: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!arm_q && cnt_q == '0));
endmodule

// File: rtl/wdt_unit_timer.sv
module wdt_unit_timer
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sys_rst_o,
  output logic       pwr_ok_o,
  output logic       tmo_evt_o
);
  logic [7:0]       cfg;
  logic             load, flag, unit_tick, expire, armed;
  logic [CNT_W-1:0] load_val, count;
  logic             rst_q, pg_low_q, evt_q;

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .cnt_val(count), .expire(expire), .rdata(reg_rdata), .cfg_o(cfg),
    .load_o(load), .load_val_o(load_val), .flag_o(flag)
  );

  wdt_prescale #(.DIV(UNIT_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sec_mode(cfg[B_SEC]),
    .restart(load), .unit_tick(unit_tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .unit_tick(unit_tick), .count(count), .armed(armed), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q    <= 1'b0;
      pg_low_q <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      if (expire && cfg[B_RST]) rst_q <= 1'b1;
      else if (sec_tick)        rst_q <= 1'b0;
      if (expire && cfg[B_PG])  pg_low_q <= 1'b1;
      else if (sec_tick)        pg_low_q <= 1'b0;
      evt_q <= expire && cfg[B_EVT];
    end
  end

  assign sys_rst_o = rst_q;
  assign pwr_ok_o  = !pg_low_q;
  assign tmo_evt_o = evt_q;

  // R6: reset request rises only from an enabled timeout
  p_rst_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(expire && cfg[B_RST]));
  // R7: power-good falls only from an enabled timeout
  p_pg_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ok_o) |-> $past(expire && cfg[B_PG]));
  // R8: event is a single-cycle pulse
  p_evt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);
  // R9: a timeout always leaves the flag set
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  // R12: no timeout while disarmed
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !expire);
endmodule

// File: tb/wdt_unit_timer_bench.sv
module wdt_unit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sys_rst_o, pwr_ok_o, tmo_evt_o;

  always #4 clk = ~clk;

  wdt_unit_timer u_wdt_unit_timer (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst_o(sys_rst_o), .pwr_ok_o(pwr_ok_o), .tmo_evt_o(tmo_evt_o)
  );

  typedef struct {
    int         kind;   // 0 rst, 1 pwr_ok, 2 event count, 3 read data
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int tests = 0, fails = 0, evt_cnt = 0, cycles = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (tmo_evt_o) evt_cnt <= evt_cnt + 1;
  end

  // monitor: compare queued expectations against the outputs
  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {7'b0, sys_rst_o};
        1: act = {7'b0, pwr_ok_o};
        2: act = 8'(evt_cnt);
        default: act = reg_rdata;
      endcase
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: got %0h expected %0h", it.req, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", cycles, 20000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic expect_val(input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    @(negedge clk);
    #2;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    expect_val(3, exp, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr(8'h74, v[15:8]);
    wr(8'h73, v[7:0]);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h72, 8'h80, "R1 cfg");
    rd(8'h73, 8'h00, "R1 count lo");
    rd(8'h74, 8'h00, "R1 count hi");
    rd(8'h71, 8'h00, "R1 flag");
    expect_val(0, 8'h0, "R1 sys_rst");
    expect_val(1, 8'h1, "R1 pwr_ok");
    tick(2);
    rd(8'h73, 8'h00, "R1 disarmed");

    // R2 configuration readback: seconds, reset, event, power-good, route 5
    wr(8'h72, 8'hF5);
    rd(8'h72, 8'hF5, "R2 cfg readback");
    // R3 high byte alone does not reach the count
    wr(8'h74, 8'h12);
    rd(8'h74, 8'h00, "R3 hi held");
    wr(8'h73, 8'h34);
    rd(8'h73, 8'h34, "R2 lo");
    rd(8'h74, 8'h12, "R3 atomic hi");
    // R10 zero load disarms
    load(16'h0000);
    tick(3);
    rd(8'h73, 8'h00, "R10 count zero");
    expect_val(0, 8'h0, "R10 no reset");
    expect_val(2, 8'd0, "R10 no event");

    // R4 seconds countdown of 3
    load(16'd3);
    tick(1);
    rd(8'h73, 8'h02, "R4 step");
    tick(1);
    expect_val(0, 8'h0, "R4 not yet");
    tick(1);
    expect_val(0, 8'h1, "R6 reset on timeout");
    expect_val(1, 8'h0, "R7 pwr_ok low");
    expect_val(2, 8'd1, "R8 one event");
    rd(8'h71, 8'h01, "R9 flag set");
    rd(8'h73, 8'h00, "R12 count zero");
    tick(1);
    expect_val(0, 8'h0, "R6 reset released");
    expect_val(1, 8'h1, "R7 pwr_ok restored");
    tick(3);
    expect_val(2, 8'd1, "R12 no refire");
    expect_val(0, 8'h0, "R12 reset quiet");

    // R9 flag clear rules
    wr(8'h71, 8'h01);
    rd(8'h71, 8'h01, "R9 write one keeps");
    wr(8'h71, 8'h00);
    rd(8'h71, 8'h00, "R9 write zero clears");

    // R11 keepalive
    load(16'd3);
    tick(2);
    load(16'd3);
    tick(2);
    expect_val(0, 8'h0, "R11 no reset after reload");
    rd(8'h73, 8'h01, "R11 restarted count");
    tick(1);
    expect_val(0, 8'h1, "R11 fires later");
    expect_val(2, 8'd2, "R8 second event");
    tick(1);

    // R6/R7 disabled actions: seconds + event only
    wr(8'h72, 8'hA0);
    load(16'd1);
    tick(1);
    expect_val(0, 8'h0, "R6 reset disabled");
    expect_val(1, 8'h1, "R7 pwr_ok disabled");
    expect_val(2, 8'd3, "R8 event enabled");
    tick(1);

    // R5 minutes mode with prescaler restart on load
    wr(8'h72, 8'h40);
    load(16'd1);
    tick(30);
    load(16'd1);
    tick(59);
    expect_val(0, 8'h0, "R5 not yet after 59");
    rd(8'h73, 8'h01, "R5 count held");
    tick(1);
    expect_val(0, 8'h1, "R5 fires at 60");
    rd(8'h73, 8'h00, "R5 count zero");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule